// File: doc/BRIEF.md
# Integer ALU with Set-Less-Than

This block is the purely combinational integer execute unit of a 32-bit load/store datapath. It takes two operands, a shift count and a 4-bit operation code. It returns a result word and a flag that is high when that word is zero. The operations are wrapping add and subtract, bitwise AND, OR and NOR, and logical shifts left and right of operand B. It also returns a one-bit less-than result in both a two's-complement and an unsigned form, and it can place the low half of operand B into the upper half of the result with the low half cleared.

A separate immediate helper inside the same top widens a 16-bit instruction constant to the full word. It sign-extends for arithmetic immediates and zero-extends for logical ones. A 32-bit constant is built in two steps: an upper-half load, then an OR with a zero-extended lower half.

The block has no state. The result settles within the same cycle as the operands and the operation code.

Top module: `alu_core`

## Requirements
- R1: Operation codes on `op` are ADD=0, SUB=1, AND=2, OR=3, NOR=4, SLL=5, SRL=6, SLT=7, SLTU=8 and UPPER=9. Codes 10 to 15 drive a result of 0.
- R2: ADD returns A+B modulo 2^32 and does not trap or flag an overflow.
- R3: SUB returns A-B modulo 2^32 and does not trap or flag an overflow.
- R4: AND, OR and NOR return the bitwise A&B, A|B and ~(A|B).
- R5: SLL and SRL shift operand B by `shamt` positions (0 to 31) and fill with zeros. SLL shifts toward bit 31 and SRL shifts toward bit 0.
- R6: SLT returns 1 in bit 0 and 0 in bits 31:1 when A is less than B as two's-complement values. Otherwise it returns 0.
- R7: SLTU returns 1 when A is less than B as unsigned values and 0 otherwise. Bits 31:1 are always 0.
- R8: UPPER returns B[15:0] in bits 31:16 and 0 in bits 15:0. Operand A is ignored.
- R9: `zero` is high exactly when `result` equals 0.
- R10: `imm_out[15:0]` equals `imm_in`. When `imm_sext` is 1, bits 31:16 all copy `imm_in[15]`, so the range -32768 to 32767 is preserved. When `imm_sext` is 0, bits 31:16 are 0.
- R11: Feeding an UPPER result with B=0x003D back as A, then applying OR with B set to the zero-extended immediate 0x0900, gives 0x003D0900.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (see R1) |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B; the shift source and the source of the upper-half constant |
| shamt | input | 5 | Shift count, 0 to 31 |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |
| imm_in | input | 16 | Instruction immediate to widen |
| imm_sext | input | 1 | 1 selects sign extension, 0 selects zero extension |
| imm_out | output | 32 | Widened immediate |

## Verification
The block holds no state, so any fault shows on `result` or `zero` in the same cycle as the inputs that expose it. A wrong carry or borrow in the shared adder makes the add, subtract and both comparison results wrong together. The comparisons are most sensitive where the operand signs differ, because there the signed and unsigned answers disagree. A wrong shifter stage shows only for shift counts that have that stage's bit set, which is why shift counts 0, 1, 16 and 31 are directed cases.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Purpose : shared operation encoding and word widths for the integer ALU.
// Assumes : a 4-bit operation code; codes not listed here are unused.
package alu_pkg;

    localparam int ALU_W  = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_NOR   = 4'd4,
        OP_SLL   = 4'd5,
        OP_SRL   = 4'd6,
        OP_SLT   = 4'd7,
        OP_SLTU  = 4'd8,
        OP_UPPER = 4'd9
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Module alu_addsub
// Purpose : one adder shared by add, subtract and both less-than compares.
//           In subtract mode it adds the inverted B plus one.
// Assumes : W >= 2. No overflow trap; the sum wraps modulo 2^W.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic         signs_differ;

    // Invert B when subtracting.
    always_comb b_eff = sub ? ~b : b;

    // Add with one extra bit that keeps the carry out.
    always_comb full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    assign sum = full[W-1:0];

    // Unsigned borrow: in subtract mode a missing carry out means a < b.
    always_comb lt_unsigned = ~full[W];

    // Signed compare: the sign of A decides when the signs differ, otherwise the sign of the difference.
    always_comb begin
        signs_differ = a[W-1] ^ b[W-1];
        lt_signed    = signs_differ ? a[W-1] : full[W-1];
    end
endmodule

// File: rtl/alu_shift.sv
// Module alu_shift
// Purpose : logarithmic shifter. LEFT picks the direction at elaboration.
//           Stage k shifts by 2^k when bit k of amt is set. Vacated bits are zero.
// Assumes : W is a power of two, and amt has $clog2(W) bits.
module alu_shift #(
    parameter int W    = 32,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         dout
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] stage [0:SHW];

    assign stage[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        if (LEFT) begin : g_left
            // Conditionally shift toward the MSB by 2^k.
            assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
        end else begin : g_right
            // Conditionally shift toward the LSB by 2^k.
            assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
        end
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/alu_bitwise.sv
// Module alu_bitwise
// Purpose : the three bitwise results, all produced in parallel.
// Assumes : nothing beyond equal operand widths.
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] nor_o
);
    // Per-bit logic, no carries.
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        nor_o = ~(a | b);
    end
endmodule

// File: rtl/alu_immext.sv
// Module alu_immext
// Purpose : widen an instruction immediate to the word width,
//           by sign extension or zero extension.
// Assumes : W > IW.
module alu_immext #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [IW-1:0] imm,
    input  logic          sext,
    output logic [W-1:0]  wide
);
    localparam int HI_W = W - IW;

    logic fill;

    // Fill bit for the upper part: the immediate's sign, or zero.
    always_comb fill = sext & imm[IW-1];

    assign wide = {{HI_W{fill}}, imm};
endmodule

// File: rtl/alu_core.sv
// Module alu_core
// Purpose : combinational integer ALU top. It selects among the adder,
//           the shifters, the bitwise unit, the compares and the upper-half
//           load, and it carries the immediate widening helper.
// Assumes : the caller registers the inputs and outputs. Unused codes give 0.
module alu_core
    import alu_pkg::*;
#(
    parameter int W  = ALU_W,
    parameter int IW = IMM_W
) (
    input  logic [OP_W-1:0]      op,
    input  logic [W-1:0]         opa,
    input  logic [W-1:0]         opb,
    input  logic [$clog2(W)-1:0] shamt,
    output logic [W-1:0]         result,
    output logic                 zero,
    input  logic [IW-1:0]        imm_in,
    input  logic                 imm_sext,
    output logic [W-1:0]         imm_out
);
    localparam int LO_W = W - IW;

    alu_op_e      op_e;
    logic         do_sub;
    logic [W-1:0] sum;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] shl;
    logic [W-1:0] shr;
    logic [W-1:0] and_r;
    logic [W-1:0] or_r;
    logic [W-1:0] nor_r;

    // Turn the raw code into the enumerated type.
    always_comb op_e = alu_op_e'(op);

    // The adder subtracts for SUB and for both compares.
    always_comb do_sub = (op_e == OP_SUB) || (op_e == OP_SLT) || (op_e == OP_SLTU);

    alu_addsub #(.W(W)) u_addsub (
        .a           (opa),
        .b           (opb),
        .sub         (do_sub),
        .sum         (sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_shift #(.W(W), .LEFT(1'b1)) u_shl (
        .din  (opb),
        .amt  (shamt),
        .dout (shl)
    );

    alu_shift #(.W(W), .LEFT(1'b0)) u_shr (
        .din  (opb),
        .amt  (shamt),
        .dout (shr)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a     (opa),
        .b     (opb),
        .and_o (and_r),
        .or_o  (or_r),
        .nor_o (nor_r)
    );

    alu_immext #(.W(W), .IW(IW)) u_immext (
        .imm  (imm_in),
        .sext (imm_sext),
        .wide (imm_out)
    );

    // Result multiplexer over the unit outputs.
    always_comb begin
        case (op_e)
            OP_ADD, OP_SUB: result = sum;
            OP_AND:         result = and_r;
            OP_OR:          result = or_r;
            OP_NOR:         result = nor_r;
            OP_SLL:         result = shl;
            OP_SRL:         result = shr;
            OP_SLT:         result = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:        result = {{(W-1){1'b0}}, lt_u};
            OP_UPPER:       result = {opb[LO_W-1:0], {IW{1'b0}}};
            default:        result = '0;
        endcase
    end

    // Zero flag: high when no result bit is set.
    always_comb zero = ~|result;
endmodule

// File: rtl/alu_core_chk.sv
// Module alu_core_chk
// Purpose : assertion checker bound to alu_core. It checks results by
//           inverse operations and by field properties, not by recomputing them.
// Assumes : combinational top, so the checks are immediate ones in a comb process.
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int W  = ALU_W,
    parameter int IW = IMM_W
) (
    input logic [OP_W-1:0]      op,
    input logic [W-1:0]         opa,
    input logic [W-1:0]         opb,
    input logic [$clog2(W)-1:0] shamt,
    input logic [W-1:0]         result,
    input logic                 zero,
    input logic [IW-1:0]        imm_in,
    input logic [W-1:0]         imm_out
);
    // Check each result by its inverse or by a field property.
    always_comb begin
        if (op == OP_ADD) begin
            a_r2_add_inverse : assert (result - opb == opa)
                else $error("R2 add result does not invert");
        end
        if (op == OP_SUB) begin
            a_r3_sub_inverse : assert (result + opb == opa)
                else $error("R3 sub result does not invert");
        end
        if (op == OP_SLL && shamt == '0) begin
            a_r5_shift_zero : assert (result == opb)
                else $error("R5 zero-count shift altered operand");
        end
        if (op == OP_SLT || op == OP_SLTU) begin
            a_r6_compare_width : assert (result[W-1:1] == '0)
                else $error("R6/R7 compare result wider than one bit");
        end
        if (op == OP_UPPER) begin
            a_r8_upper_place : assert (result[IW-1:0] == '0 && result[W-1:W-IW] == opb[IW-1:0])
                else $error("R8 upper placement wrong");
        end
        if (zero) begin
            a_r9_zero_means_empty : assert ($countones(result) == 0)
                else $error("R9 zero flag with set result bits");
        end
        a_r10_imm_low_kept : assert (imm_out[IW-1:0] == imm_in)
            else $error("R10 immediate low half altered");
    end
endmodule

bind alu_core alu_core_chk #(.W(W), .IW(IW)) u_chk (
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .shamt   (shamt),
    .result  (result),
    .zero    (zero),
    .imm_in  (imm_in),
    .imm_out (imm_out)
);

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]  op;
    logic [31:0] opa, opb;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        zero;
    logic [15:0] imm_in;
    logic        imm_sext;
    logic [31:0] imm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    alu_core u_alu_core (
        .op(op), .opa(opa), .opb(opb), .shamt(shamt),
        .result(result), .zero(zero),
        .imm_in(imm_in), .imm_sext(imm_sext), .imm_out(imm_out)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] s);
        case (o)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return ~(a | b);
            4'd5: return b << s;
            4'd6: return b >> s;
            4'd7: return {31'd0, ($signed(a) < $signed(b))};
            4'd8: return {31'd0, (a < b)};
            4'd9: return {b[15:0], 16'h0000};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rtag(input logic [3:0] o);
        case (o)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, then sample 2 ns later.
    task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] s);
        logic [31:0] e;
        @(negedge clk);
        op = o; opa = a; opb = b; shamt = s;
        #2;
        e = model(o, a, b, s);
        check32(rtag(o), result, e);
        check32("R9", {31'd0, zero}, {31'd0, (e == 32'd0)});
    endtask

    task automatic run_imm(input logic [15:0] i, input logic sx);
        logic [31:0] e;
        @(negedge clk);
        imm_in = i; imm_sext = sx;
        #2;
        e = sx ? {{16{i[15]}}, i} : {16'h0000, i};
        check32("R10", imm_out, e);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A1B));
        op = 4'd0; opa = '0; opb = '0; shamt = '0; imm_in = '0; imm_sext = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet inputs: ADD of zeros gives 0 with the zero flag set (R2, R9).
        #2;
        check32("R9", {31'd0, zero}, 32'd1);
        check32("R2", result, 32'd0);

        // Directed corner cases.
        run_op(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);           // R2 wrap to zero
        run_op(4'd1, 32'h8000_0000, 32'd1, 5'd0);           // R3 wrap
        run_op(4'd1, 32'd5, 32'd5, 5'd0);                   // R3 equal -> zero
        run_op(4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0);   // R4
        run_op(4'd4, 32'd0, 32'd0, 5'd0);                   // R4 NOR all ones
        run_op(4'd5, 32'd0, 32'h0000_0001, 5'd31);          // R5 max left
        run_op(4'd6, 32'd0, 32'h8000_0000, 5'd31);          // R5 max right
        run_op(4'd5, 32'd0, 32'hDEAD_BEEF, 5'd0);           // R5 zero count
        run_op(4'd6, 32'd0, 32'hDEAD_BEEF, 5'd16);          // R5 half
        run_op(4'd5, 32'd0, 32'hDEAD_BEEF, 5'd1);           // R5 single
        run_op(4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0);           // R6 -1 < 1
        run_op(4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);           // R7 unsigned no
        run_op(4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);   // R6 max vs min
        run_op(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);   // R7
        run_op(4'd7, 32'd3, 32'd3, 5'd0);                   // R6 equal
        run_op(4'd9, 32'hAAAA_AAAA, 32'h1234_5678, 5'd0);   // R8 A ignored
        run_op(4'd12, 32'h1234, 32'h5678, 5'd3);            // R1 unused code
        run_op(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7);  // R1 unused code

        // R10 immediate widening corners.
        run_imm(16'h8000, 1'b1);
        run_imm(16'h8000, 1'b0);
        run_imm(16'h7FFF, 1'b1);
        run_imm(16'hFFFF, 1'b1);

        // R11: upper load, then OR with zero-extended lower half.
        begin
            logic [31:0] upper;
            @(negedge clk);
            op = 4'd9; opa = '0; opb = 32'h0000_003D; shamt = '0;
            imm_in = 16'h0900; imm_sext = 1'b0;
            #2;
            upper = result;
            @(negedge clk);
            op = 4'd3; opa = upper; opb = imm_out;
            #2;
            check32("R11", result, 32'h003D_0900);
        end

        // Random mix over all codes.
        for (int n = 0; n < 4000; n++) begin
            run_op(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom_range(0, 31)));
        end
        for (int n = 0; n < 200; n++) begin
            run_imm(16'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule